// File: doc/BRIEF.md
# CAN receive message FIFO

This block holds received CAN frames for a controller until the CPU reads them. A frame assembler writes each finished frame into a single background buffer, together with a strobe that says the frame is valid and passed the identifier filter. One cycle later the frame moves into a queue, unless the controller was sending at that moment. The queue has a fixed number of entries. The oldest entry sits in a CPU-visible slot, and a ready flag marks it as valid.

Software reads the visible frame and then writes 1 to a clear input. That write releases the slot, and the next queued frame, if there is one, moves up. When every entry is taken, any further accepted frame is dropped and a sticky overrun status is set. The frames already stored are left untouched. Two interrupt outputs gate the ready flag and the overrun status with their enables.

Top module: `can_rx_queue`

## Requirements
- R1: After a synchronous reset the following are all 0: `frame_rdy`, `overrun`, `occ`, `rx_irq` and `err_irq`.
- R2: The queue may be empty and `tx_busy` low while `rx_done` is high. The frame's identifier, length code, data and hit index then appear unchanged on the `q_*` outputs. `frame_rdy` becomes 1 after the third rising edge, counting the edge that samples the strobe. `occ` becomes 1 one edge earlier.
- R3: `rx_irq` always equals `frame_rdy & rx_ie`. `err_irq` always equals `overrun & err_ie`.
- R4: Frames leave the queue in the order they were accepted.
- R5: `clr_rxf` is write-1-to-clear. If it is high while `frame_rdy` is 1, `frame_rdy` is 0 after that edge. If another frame is queued, it is shown with `frame_rdy` 1 after the following edge. If `clr_rxf` is high while `frame_rdy` is 0, it has no effect.
- R6: If `tx_busy` is high when `rx_done` is sampled, the frame is captured but not queued. `occ` does not change and `frame_rdy` does not rise.
- R7: The queue holds DEPTH frames (default 5), and this count includes the visible slot. `occ` reports how many frames are stored.
- R8: If an accepted frame arrives while `occ` equals DEPTH, that frame is discarded and `overrun` becomes 1. The stored frames and the visible frame do not change.
- R9: As soon as an entry is freed, the next accepted frame is queued again.
- R10: `clr_ovr` is write-1-to-clear for `overrun`, and `overrun` otherwise stays set. A new overrun in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Frame valid and accepted strobe |
| rx_id | input | 32 | Identifier field of the finished frame |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Eight data bytes |
| rx_hit | input | 3 | Filter hit index |
| tx_busy | input | 1 | Controller is transmitting |
| clr_rxf | input | 1 | Write-1-to-clear of the ready flag |
| clr_ovr | input | 1 | Write-1-to-clear of the overrun status |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Overrun interrupt enable |
| q_id | output | 32 | Visible frame identifier |
| q_dlc | output | 4 | Visible frame length code |
| q_data | output | 64 | Visible frame data |
| q_hit | output | 3 | Visible frame hit index |
| frame_rdy | output | 1 | Visible slot holds a valid frame |
| overrun | output | 1 | Sticky overrun status |
| occ | output | 3 | Number of stored frames |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
Directed tests drive the queue with several input patterns, and each pattern separates one behaviour from the others.
- A lone frame checks the transfer latency and that every field comes through intact.
- Three frames sent back to back check ordering and the one-cycle gap after each clear. A clear issued during that gap is shown to be ignored.
- A frame sent while transmitting is shown never to enter the queue.
- The queue is filled to capacity and then sent one more frame. This shows that the newest frame is the one dropped, with the visible and stored frames unchanged.
- One entry is then freed and a frame is sent, which shows that the queue accepts frames again at once.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
  localparam int CAN_ID_W   = 32;
  localparam int CAN_DLC_W  = 4;
  localparam int CAN_DATA_W = 64;
  localparam int CAN_HIT_W  = 3;

  typedef struct packed {
    logic [CAN_ID_W-1:0]   id;
    logic [CAN_DLC_W-1:0]  dlc;
    logic [CAN_DATA_W-1:0] data;
    logic [CAN_HIT_W-1:0]  hit;
  } rx_frame_t;
endpackage

// File: rtl/can_rxq_bgbuf.sv
module can_rxq_bgbuf
  import can_rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strobe_i,
  input  logic      tx_i,
  input  rx_frame_t frame_i,
  output rx_frame_t bg_o,
  output logic      push_o
);
  rx_frame_t bg_q;
  logic      pend_q;

  // the frame is always captured; own transmissions never request a push
  always_ff @(posedge clk) begin
    if (strobe_i) bg_q <= frame_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= strobe_i & ~tx_i;
  end

  assign bg_o   = bg_q;
  assign push_o = pend_q;

  p_self_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && tx_i) |=> !push_o);
endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  rx_frame_t                  frame_i,
  input  logic                       clr_i,
  output rx_frame_t                  vis_o,
  output logic                       rdy_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] occ_o
);
  localparam int BDEPTH = DEPTH - 1;
  localparam int PTR_W  = (BDEPTH > 1) ? $clog2(BDEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  rx_frame_t        mem [BDEPTH];
  rx_frame_t        vis_q;
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] bcnt_q;
  logic             rdy_q;
  logic             accept, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(BDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign occ_o  = CNT_W'(rdy_q) + bcnt_q;
  assign full_o = (occ_o == CNT_W'(DEPTH));
  assign accept = push_i & ~full_o;
  assign pop    = ~rdy_q & (bcnt_q != '0);

  // backing ring: plain write port and registered read, RAM friendly
  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= frame_i;
  end

  always_ff @(posedge clk) begin
    if (pop) vis_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      bcnt_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (accept) wptr_q <= ptr_inc(wptr_q);
      if (pop)    rptr_q <= ptr_inc(rptr_q);
      bcnt_q <= bcnt_q + CNT_W'(accept) - CNT_W'(pop);
      if (pop)                rdy_q <= 1'b1;
      else if (clr_i && rdy_q) rdy_q <= 1'b0;
    end
  end

  assign vis_o = vis_q;
  assign rdy_o = rdy_q;

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    occ_o <= CNT_W'(DEPTH));
  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (full_o && !clr_i) |=> full_o);
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (!rdy_q && bcnt_q != '0) |=> rdy_q);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && clr_i) |=> !rdy_q);
  p_vis_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !clr_i) |=> $stable(vis_q));
endmodule

// File: rtl/can_rxq_status.sv
module can_rxq_status (
  input  logic clk,
  input  logic rst,
  input  logic ovr_set_i,
  input  logic clr_ovr_i,
  input  logic rdy_i,
  input  logic rx_ie_i,
  input  logic err_ie_i,
  output logic ovr_o,
  output logic rx_irq_o,
  output logic err_irq_o
);
  logic ovr_q;

  always_ff @(posedge clk) begin
    if (rst)            ovr_q <= 1'b0;
    else if (ovr_set_i) ovr_q <= 1'b1;
    else if (clr_ovr_i) ovr_q <= 1'b0;
  end

  assign ovr_o     = ovr_q;
  assign rx_irq_o  = rdy_i & rx_ie_i;
  assign err_irq_o = ovr_q & err_ie_i;

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    ovr_set_i |=> ovr_o);
  p_ovr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !clr_ovr_i) |=> ovr_o);
endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_done,
  input  logic [CAN_ID_W-1:0]        rx_id,
  input  logic [CAN_DLC_W-1:0]       rx_dlc,
  input  logic [CAN_DATA_W-1:0]      rx_data,
  input  logic [CAN_HIT_W-1:0]       rx_hit,
  input  logic                       tx_busy,
  input  logic                       clr_rxf,
  input  logic                       clr_ovr,
  input  logic                       rx_ie,
  input  logic                       err_ie,
  output logic [CAN_ID_W-1:0]        q_id,
  output logic [CAN_DLC_W-1:0]       q_dlc,
  output logic [CAN_DATA_W-1:0]      q_data,
  output logic [CAN_HIT_W-1:0]       q_hit,
  output logic                       frame_rdy,
  output logic                       overrun,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       rx_irq,
  output logic                       err_irq
);
  rx_frame_t in_frame, bg_frame, vis_frame;
  logic      push, full, ovr_set;

  assign in_frame = '{id: rx_id, dlc: rx_dlc, data: rx_data, hit: rx_hit};

  can_rxq_bgbuf u_bg (
    .clk(clk), .rst(rst), .strobe_i(rx_done), .tx_i(tx_busy),
    .frame_i(in_frame), .bg_o(bg_frame), .push_o(push)
  );

  can_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_i(push), .frame_i(bg_frame), .clr_i(clr_rxf),
    .vis_o(vis_frame), .rdy_o(frame_rdy), .full_o(full), .occ_o(occ)
  );

  assign ovr_set = push & full;

  can_rxq_status u_stat (
    .clk(clk), .rst(rst), .ovr_set_i(ovr_set), .clr_ovr_i(clr_ovr),
    .rdy_i(frame_rdy), .rx_ie_i(rx_ie), .err_ie_i(err_ie),
    .ovr_o(overrun), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  assign q_id   = vis_frame.id;
  assign q_dlc  = vis_frame.dlc;
  assign q_data = vis_frame.data;
  assign q_hit  = vis_frame.hit;

  p_drop_keeps_occ_r8: assert property (@(posedge clk) disable iff (rst)
    (ovr_set && !clr_rxf) |=> occ == $past(occ));
endmodule

// File: tb/can_rx_queue_bench.sv
module can_rx_queue_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_done = 1'b0, tx_busy = 1'b0, clr_rxf = 1'b0, clr_ovr = 1'b0;
  logic        rx_ie = 1'b0, err_ie = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [2:0]  rx_hit = '0;
  logic [31:0] q_id;
  logic [3:0]  q_dlc;
  logic [63:0] q_data;
  logic [2:0]  q_hit;
  logic        frame_rdy, overrun, rx_irq, err_irq;
  logic [2:0]  occ;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  can_rx_queue u_can_rx_queue (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rx_hit(rx_hit), .tx_busy(tx_busy), .clr_rxf(clr_rxf),
    .clr_ovr(clr_ovr), .rx_ie(rx_ie), .err_ie(err_ie), .q_id(q_id),
    .q_dlc(q_dlc), .q_data(q_data), .q_hit(q_hit), .frame_rdy(frame_rdy),
    .overrun(overrun), .occ(occ), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_id(int k);   return 32'h1A00_0000 + k; endfunction
  function automatic logic [3:0]  f_dlc(int k);  return 4'(k % 9); endfunction
  function automatic logic [63:0] f_data(int k); return {8{8'(k)}} ^ 64'h0123_4567_89AB_CDEF; endfunction
  function automatic logic [2:0]  f_hit(int k);  return 3'(k % 8); endfunction

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_vis(string req, int k);
    chk(req, "q_id", 64'(q_id), 64'(f_id(k)));
    chk(req, "q_dlc", 64'(q_dlc), 64'(f_dlc(k)));
    chk(req, "q_data", q_data, f_data(k));
    chk(req, "q_hit", 64'(q_hit), 64'(f_hit(k)));
  endtask

  // drive one strobe cycle; returns at the negedge after the sampling edge
  task automatic send(int k, logic tx);
    rx_id = f_id(k); rx_dlc = f_dlc(k); rx_data = f_data(k); rx_hit = f_hit(k);
    rx_done = 1'b1; tx_busy = tx;
    cyc();
    rx_done = 1'b0; tx_busy = 1'b0;
  endtask

  task automatic pulse_clr();
    clr_rxf = 1'b1; cyc(); clr_rxf = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "frame_rdy", 64'(frame_rdy), 0);
    chk("R1", "overrun", 64'(overrun), 0);
    chk("R1", "occ", 64'(occ), 0);
    chk("R1", "rx_irq", 64'(rx_irq), 0);
    chk("R1", "err_irq", 64'(err_irq), 0);
  endtask

  task automatic t_single();
    rx_ie = 1'b1;
    send(1, 1'b0);
    cyc();
    chk("R2", "frame_rdy early", 64'(frame_rdy), 0);
    chk("R7", "occ after push", 64'(occ), 1);
    cyc();
    chk("R2", "frame_rdy", 64'(frame_rdy), 1);
    chk_vis("R2", 1);
    chk("R3", "rx_irq enabled", 64'(rx_irq), 1);
    rx_ie = 1'b0; cyc();
    chk("R3", "rx_irq disabled", 64'(rx_irq), 0);
    pulse_clr();
    chk("R5", "frame_rdy cleared", 64'(frame_rdy), 0);
    chk("R7", "occ empty", 64'(occ), 0);
  endtask

  task automatic t_order();
    send(2, 1'b0); send(3, 1'b0); send(4, 1'b0);
    cyc(3);
    chk("R7", "occ three", 64'(occ), 3);
    chk_vis("R4", 2);
    pulse_clr();
    chk("R5", "gap after clear", 64'(frame_rdy), 0);
    cyc();
    chk("R5", "next shown", 64'(frame_rdy), 1);
    chk_vis("R4", 3);
    pulse_clr();
    chk("R5", "gap after clear", 64'(frame_rdy), 0);
    pulse_clr(); // clear while flag is 0 is ignored
    chk("R5", "clear in gap ignored", 64'(frame_rdy), 1);
    chk_vis("R4", 4);
    pulse_clr(); cyc();
    chk("R5", "drained", 64'(frame_rdy), 0);
    chk("R7", "occ drained", 64'(occ), 0);
  endtask

  task automatic t_self();
    rx_ie = 1'b1;
    send(5, 1'b1);
    cyc(3);
    chk("R6", "occ unchanged", 64'(occ), 0);
    chk("R6", "frame_rdy", 64'(frame_rdy), 0);
    chk("R6", "rx_irq", 64'(rx_irq), 0);
    send(6, 1'b0);
    cyc(3);
    chk_vis("R6", 6);
    pulse_clr(); cyc();
    rx_ie = 1'b0;
  endtask

  task automatic t_overrun();
    err_ie = 1'b0;
    for (int k = 10; k < 15; k++) send(k, 1'b0);
    cyc(3);
    chk("R7", "occ full", 64'(occ), 5);
    chk("R8", "no overrun yet", 64'(overrun), 0);
    send(15, 1'b0);
    cyc(3);
    chk("R8", "overrun set", 64'(overrun), 1);
    chk("R8", "occ kept", 64'(occ), 5);
    chk_vis("R8", 10);
    chk("R3", "err_irq disabled", 64'(err_irq), 0);
    err_ie = 1'b1; cyc();
    chk("R3", "err_irq enabled", 64'(err_irq), 1);
    pulse_clr(); cyc();
    chk_vis("R4", 11);
    chk("R9", "occ freed", 64'(occ), 4);
    send(16, 1'b0);
    cyc(3);
    chk("R9", "occ refilled", 64'(occ), 5);
    chk("R10", "overrun sticky", 64'(overrun), 1);
    pulse_clr(); cyc(); chk_vis("R8", 12);
    pulse_clr(); cyc(); chk_vis("R8", 13);
    pulse_clr(); cyc(); chk_vis("R8", 14);
    pulse_clr(); cyc(); chk_vis("R9", 16);
    pulse_clr(); cyc();
    chk("R7", "occ drained", 64'(occ), 0);
    clr_ovr = 1'b1; cyc(); clr_ovr = 1'b0;
    chk("R10", "overrun cleared", 64'(overrun), 0);
    chk("R3", "err_irq after clear", 64'(err_irq), 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc();
    t_reset();
    t_single();
    t_order();
    t_self();
    t_overrun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule